// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-and-ALU half of a small processor built around one shared bus. It holds eight general registers, a program counter, an instruction register, a memory address register, a memory data register, an ALU operand latch (Y), an ALU result latch (Z) and a four-bit condition-code register. An external sequencer, which is outside this block, drives a flat control word every clock cycle. Each bit of that word either lets one register drive the bus, lets a register capture the bus, or steers the adder. Any bit left low is inactive for that cycle. All bits raised in the same cycle act together at the next rising edge.

The adder takes its first operand from Y, or from a forced zero, and its second operand from the bus. Its result cannot reach the bus directly. It can only be latched into Z. Z is an edge-triggered register, so it can drive the bus and capture a new sum in the same cycle, which lets a sequence accumulate several operands. Raising the forced-zero and carry-in bits together with the add bit produces bus+1, which is how the sequencer advances the program counter. The condition codes change only in cycles that request it.

Memory is reached through a simple port. The address comes from the memory address register, a read strobe is passed straight through from the control word, and the data register captures returned data in the cycle in which memory signals completion.

Top module: `onebus_datapath`

## Requirements
- R1: After an asynchronous active-low reset, every register (general registers, PC, IR, MAR, MDR, Y, Z, condition codes) reads zero. With no bus source enabled, the bus carries zero.
- R2: The control word is 30 bits wide. Bits [7:0] let general register k drive the bus. Bit 16 lets the PC drive it, bit 18 lets Z drive it, bit 21 lets the MDR drive it, and bit 23 lets the IR address field drive it. At most one of these is active in a cycle, and the bus then equals the selected register.
- R3: Bit 26 is add, bit 27 forces the first operand to zero, and bit 28 is carry-in. When Z load (bit 19) and add are both set, Z captures (Y or 0) + bus + carry-in, modulo 2^16. When Z load is set and add is clear, Z captures the bus unchanged.
- R4: Y captures the bus only when bit 20 is set. Forcing the first operand to zero leaves the stored Y unchanged.
- R5: Z holds its value in any cycle without Z load. When Z drives the bus and captures a new sum in the same cycle, the sum uses Z's old value.
- R6: The condition codes are cc[3]=N (result bit 15), cc[2]=Z (result is zero), cc[1]=V (signed overflow of the add) and cc[0]=C (adder carry-out). They load only when bit 29 is set and otherwise hold. A pass-through result gives V=C=0.
- R7: With bit 22 set, the IR captures the bus. The IR address field that goes onto the bus is the low 8 bits of the IR, zero-extended to 16 bits.
- R8: Bit 24 loads the MAR from the bus, and the MAR drives mem_addr. Bit 25 appears on mem_rd in the same cycle.
- R9: The MDR captures mem_rdata at a clock edge only when mem_mfc is high. Otherwise it holds its value, whatever mem_rdata carries.
- R10: Bits [15:8] load general register k from the bus, and bit 17 loads the PC from the bus, each at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 30 | Per-cycle control word |
| mem_addr | output | 16 | Memory address taken from the MAR |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Data returned by memory |
| mem_mfc | input | 1 | Memory function complete |
| bus_o | output | 16 | Value on the shared bus this cycle |
| cc_o | output | 4 | Condition codes {N, Z, V, C} |

## Verification
The checker takes as given that the sequencer never raises more than one bus-source bit in a cycle. It flags any cycle that does, because the result would be a merge of the two sources rather than a defined value. Every control word in the stimulus names at most one source, and memory data is brought in only through the MDR on completion cycles. The other properties assume that mem_mfc and ctrl are stable around the clock edge. The bench makes sure of this by changing every input on the falling edge.

// File: rtl/onebus_pkg.sv
package onebus_pkg;
    localparam int DW   = 16;
    localparam int NREG = 8;
    localparam int AFW  = 8;
    localparam int CCW  = 4;

    // control word layout
    localparam int RO_LSB  = 0;
    localparam int RI_LSB  = NREG;
    localparam int PC_OUT  = 2 * NREG;
    localparam int PC_IN   = PC_OUT + 1;
    localparam int Z_OUT   = PC_OUT + 2;
    localparam int Z_IN    = PC_OUT + 3;
    localparam int Y_IN    = PC_OUT + 4;
    localparam int MDR_OUT = PC_OUT + 5;
    localparam int IR_IN   = PC_OUT + 6;
    localparam int IRF_OUT = PC_OUT + 7;
    localparam int MAR_IN  = PC_OUT + 8;
    localparam int RD      = PC_OUT + 9;
    localparam int ADD     = PC_OUT + 10;
    localparam int ZERO_A  = PC_OUT + 11;
    localparam int CIN     = PC_OUT + 12;
    localparam int SET_CC  = PC_OUT + 13;
    localparam int CTRL_W  = PC_OUT + 14;

    // bus source indices beyond the general registers
    localparam int SRC_PC  = NREG;
    localparam int SRC_Z   = NREG + 1;
    localparam int SRC_MDR = NREG + 2;
    localparam int SRC_IRF = NREG + 3;
    localparam int NSRC    = NREG + 4;

    typedef struct packed {
        logic [DW-1:0]  pc;
        logic [DW-1:0]  ir;
        logic [DW-1:0]  mar;
        logic [DW-1:0]  mdr;
        logic [DW-1:0]  y;
        logic [DW-1:0]  z;
        logic [CCW-1:0] cc;
    } dp_state_t;
endpackage

// File: rtl/onebus_regfile.sv
module onebus_regfile #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata [N]
);
    logic [W-1:0] regs_d [N];
    logic [W-1:0] regs_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = we[i] ? wdata : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_rd
        assign rdata[g] = regs_q[g];
    end
endmodule

// File: rtl/onebus_busmux.sv
module onebus_busmux #(
    parameter int W = 16,
    parameter int N = 12
) (
    input  logic [N-1:0] sel,
    input  logic [W-1:0] src [N],
    output logic [W-1:0] bus
);
    // AND-OR merge: a single enable yields that source, none yields zero
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | (src[i] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/onebus_alu.sv
module onebus_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_add,
    input  logic         zero_a,
    input  logic         cin,
    output logic [W-1:0] result,
    output logic [3:0]   flags
);
    logic [W-1:0] a_gated;
    logic [W:0]   sum;
    logic         c_out;
    logic         v_out;

    always_comb begin
        a_gated = opa & {W{~zero_a}};
        sum     = {1'b0, a_gated} + {1'b0, opb} + {{W{1'b0}}, cin};
        if (do_add) begin
            result = sum[W-1:0];
            c_out  = sum[W];
            v_out  = (a_gated[W-1] == opb[W-1]) && (sum[W-1] != opb[W-1]);
        end else begin
            result = opb;
            c_out  = 1'b0;
            v_out  = 1'b0;
        end
        flags = {result[W-1], (result == '0), v_out, c_out};
    end
endmodule

// File: rtl/onebus_datapath.sv
module onebus_datapath
    import onebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DW-1:0]     mem_addr,
    output logic              mem_rd,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_mfc,
    output logic [DW-1:0]     bus_o,
    output logic [CCW-1:0]    cc_o
);
    dp_state_t      st_d;
    dp_state_t      st_q;
    logic [DW-1:0]  gpr     [NREG];
    logic [DW-1:0]  src_val [NSRC];
    logic [NSRC-1:0] src_sel;
    logic [DW-1:0]  alu_res;
    logic [3:0]     alu_flags;
    logic [DW-1:0]  ir_field;

    onebus_regfile #(.W(DW), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl[RI_LSB +: NREG]),
        .wdata (bus_o),
        .rdata (gpr)
    );

    assign ir_field = {{(DW-AFW){1'b0}}, st_q.ir[AFW-1:0]};

    for (genvar g = 0; g < NREG; g++) begin : g_src
        assign src_val[g] = gpr[g];
    end
    assign src_val[SRC_PC]  = st_q.pc;
    assign src_val[SRC_Z]   = st_q.z;
    assign src_val[SRC_MDR] = st_q.mdr;
    assign src_val[SRC_IRF] = ir_field;

    assign src_sel = {ctrl[IRF_OUT], ctrl[MDR_OUT], ctrl[Z_OUT], ctrl[PC_OUT],
                      ctrl[RO_LSB +: NREG]};

    onebus_busmux #(.W(DW), .N(NSRC)) u_bus (
        .sel (src_sel),
        .src (src_val),
        .bus (bus_o)
    );

    onebus_alu #(.W(DW)) u_alu (
        .opa    (st_q.y),
        .opb    (bus_o),
        .do_add (ctrl[ADD]),
        .zero_a (ctrl[ZERO_A]),
        .cin    (ctrl[CIN]),
        .result (alu_res),
        .flags  (alu_flags)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl[PC_IN])  st_d.pc  = bus_o;
        if (ctrl[IR_IN])  st_d.ir  = bus_o;
        if (ctrl[MAR_IN]) st_d.mar = bus_o;
        if (ctrl[Y_IN])   st_d.y   = bus_o;
        if (ctrl[Z_IN])   st_d.z   = alu_res;
        if (ctrl[SET_CC]) st_d.cc  = alu_flags;
        if (mem_mfc)      st_d.mdr = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr = st_q.mar;
    assign mem_rd   = ctrl[RD];
    assign cc_o     = st_q.cc;
endmodule

// File: rtl/onebus_checker.sv
module onebus_checker
    import onebus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl,
    input logic [DW-1:0]     bus_o,
    input logic [DW-1:0]     mem_addr,
    input logic [CCW-1:0]    cc_o,
    input logic [DW-1:0]     y_q,
    input logic [DW-1:0]     z_q
);
    logic [NSRC-1:0] drivers;
    assign drivers = {ctrl[IRF_OUT], ctrl[MDR_OUT], ctrl[Z_OUT], ctrl[PC_OUT],
                      ctrl[RO_LSB +: NREG]};

    a_r2_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drivers) <= 1);

    a_r6_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[SET_CC] |=> $stable(cc_o));

    a_r4_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[Y_IN] |=> $stable(y_q));

    a_r5_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[Z_IN] |=> $stable(z_q));

    a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[Z_IN] && ctrl[ADD] && ctrl[ZERO_A]) |=>
            z_q == DW'($past(bus_o) + DW'($past(ctrl[CIN]))));

    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[Z_IN] && !ctrl[ADD]) |=> z_q == $past(bus_o));

    a_r8_mar_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[MAR_IN] |=> mem_addr == $past(bus_o));
endmodule

bind onebus_datapath onebus_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .bus_o    (bus_o),
    .mem_addr (mem_addr),
    .cc_o     (cc_o),
    .y_q      (st_q.y),
    .z_q      (st_q.z)
);

// File: tb/onebus_datapath_tb.sv
module onebus_datapath_tb;
    import onebus_pkg::*;

    localparam logic [29:0] PCO  = 30'd1 << 16;
    localparam logic [29:0] PCI  = 30'd1 << 17;
    localparam logic [29:0] ZO   = 30'd1 << 18;
    localparam logic [29:0] ZI   = 30'd1 << 19;
    localparam logic [29:0] YI   = 30'd1 << 20;
    localparam logic [29:0] MDRO = 30'd1 << 21;
    localparam logic [29:0] IRI  = 30'd1 << 22;
    localparam logic [29:0] IRFO = 30'd1 << 23;
    localparam logic [29:0] MARI = 30'd1 << 24;
    localparam logic [29:0] RDB  = 30'd1 << 25;
    localparam logic [29:0] ADDB = 30'd1 << 26;
    localparam logic [29:0] ZA   = 30'd1 << 27;
    localparam logic [29:0] CI   = 30'd1 << 28;
    localparam logic [29:0] SCC  = 30'd1 << 29;

    function automatic logic [29:0] ro(input int k);
        return 30'd1 << k;
    endfunction
    function automatic logic [29:0] ri(input int k);
        return 30'd1 << (8 + k);
    endfunction
    // {req, ctrl, rdata, mfc, check, expected bus}
    function automatic logic [67:0] row(input logic [3:0] r, input logic [29:0] c,
                                        input logic [15:0] d, input logic m,
                                        input logic k, input logic [15:0] e);
        return {r, c, d, m, k, e};
    endfunction

    localparam int NROW = 24;
    localparam logic [67:0] PROG [NROW] = '{
        row(4'd1,  30'd0,             16'h1234, 1'b1, 1'b1, 16'h0000), // R1 idle bus
        row(4'd9,  MDRO | ri(1),      16'h0000, 1'b0, 1'b1, 16'h1234), // R9
        row(4'd1,  30'd0,             16'h0F0F, 1'b1, 1'b1, 16'h0000),
        row(4'd10, MDRO | ri(2),      16'h0000, 1'b0, 1'b1, 16'h0F0F), // R10
        row(4'd2,  ro(1) | YI,        16'h0000, 1'b0, 1'b1, 16'h1234), // R2
        row(4'd2,  ro(2) | ADDB | ZI, 16'h0000, 1'b0, 1'b1, 16'h0F0F),
        row(4'd3,  ZO | ri(2),        16'h0000, 1'b0, 1'b1, 16'h2143), // R3 sum
        row(4'd10, ro(2),             16'h0000, 1'b0, 1'b1, 16'h2143),
        row(4'd1,  30'd0,             16'h0001, 1'b1, 1'b1, 16'h0000),
        row(4'd9,  MDRO | ri(3),      16'h0000, 1'b0, 1'b1, 16'h0001),
        row(4'd2,  ro(1) | YI,        16'h0000, 1'b0, 1'b1, 16'h1234),
        row(4'd2,  ro(2) | ADDB | ZI, 16'h0000, 1'b0, 1'b1, 16'h2143),
        row(4'd2,  ro(3) | YI,        16'h0000, 1'b0, 1'b1, 16'h0001),
        row(4'd5,  ZO | ADDB | ZI,    16'h0000, 1'b0, 1'b1, 16'h3377), // R5 read+write
        row(4'd5,  ZO,                16'h0000, 1'b0, 1'b1, 16'h3378),
        row(4'd3,  PCO|ZA|CI|ADDB|ZI|MARI|RDB, 16'h0000, 1'b0, 1'b1, 16'h0000),
        row(4'd3,  ZO | PCI,          16'h0000, 1'b0, 1'b1, 16'h0001), // R3 increment
        row(4'd10, PCO,               16'h0000, 1'b0, 1'b1, 16'h0001),
        row(4'd4,  MDRO | ADDB | ZI,  16'h0000, 1'b0, 1'b1, 16'h0001), // R4
        row(4'd4,  ZO,                16'h0000, 1'b0, 1'b1, 16'h0002),
        row(4'd1,  30'd0,             16'hAB5C, 1'b1, 1'b1, 16'h0000),
        row(4'd7,  MDRO | IRI,        16'h0000, 1'b0, 1'b1, 16'hAB5C), // R7
        row(4'd7,  IRFO,              16'h0000, 1'b0, 1'b1, 16'h005C),
        row(4'd9,  MDRO,              16'h5555, 1'b0, 1'b1, 16'hAB5C)  // R9 no mfc
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CTRL_W-1:0] ctrl = '0;
    logic [DW-1:0]     mem_addr;
    logic              mem_rd;
    logic [DW-1:0]     mem_rdata = '0;
    logic              mem_mfc = 1'b0;
    logic [DW-1:0]     bus_o;
    logic [CCW-1:0]    cc_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    onebus_datapath u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .mem_mfc   (mem_mfc),
        .bus_o     (bus_o),
        .cc_o      (cc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on the falling edge, leave time to settle before the rising edge
    task automatic step(input logic [29:0] c, input logic [15:0] d, input logic m);
        @(negedge clk);
        ctrl      = c;
        mem_rdata = d;
        mem_mfc   = m;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 bus", 32'(bus_o), 32'h0);
        check("R1 cc", 32'(cc_o), 32'h0);
        check("R1 mar", 32'(mem_addr), 32'h0);
        rst_n = 1'b1;
        step(ZO, 16'h0, 1'b0);
        check("R1 z", 32'(bus_o), 32'h0);
        step(PCO, 16'h0, 1'b0);
        check("R1 pc", 32'(bus_o), 32'h0);

        for (int i = 0; i < NROW; i++) begin
            step(PROG[i][63:34], PROG[i][33:18], PROG[i][17]);
            if (PROG[i][16])
                check($sformatf("R%0d row %0d", PROG[i][67:64], i),
                      32'(bus_o), 32'(PROG[i][15:0]));
        end

        // R8 address field into MAR, read strobe follows the control bit
        step(IRFO | MARI, 16'h0, 1'b0);
        step(RDB, 16'h0, 1'b0);
        check("R8 addr", 32'(mem_addr), 32'h005C);
        check("R8 rd high", 32'(mem_rd), 32'h1);
        step(30'd0, 16'h0, 1'b0);
        check("R8 rd low", 32'(mem_rd), 32'h0);

        // R6 no set_cc so far: codes still zero
        check("R6 hold after adds", 32'(cc_o), 32'h0);
        step(30'd0, 16'h7FFF, 1'b1);
        step(MDRO | YI, 16'h0, 1'b0);
        step(30'd0, 16'h0001, 1'b1);
        step(MDRO | ADDB | ZI | SCC, 16'h0, 1'b0);
        step(ZO, 16'h0, 1'b0);
        check("R3 7fff+1", 32'(bus_o), 32'h8000);
        check("R6 overflow NZVC", 32'(cc_o), 32'b1010);
        step(MDRO | ADDB | ZI, 16'h0, 1'b0);
        step(30'd0, 16'h0, 1'b0);
        check("R6 hold no setcc", 32'(cc_o), 32'b1010);
        step(30'd0, 16'hFFFF, 1'b1);
        step(MDRO | YI, 16'h0, 1'b0);
        step(30'd0, 16'h0001, 1'b1);
        step(MDRO | ADDB | ZI | SCC, 16'h0, 1'b0);
        step(ZO, 16'h0, 1'b0);
        check("R6 carry zero NZVC", 32'(cc_o), 32'b0101);
        check("R3 wrap", 32'(bus_o), 32'h0000);

        // R3 pass-through without add ignores Y
        step(30'd0, 16'hABCD, 1'b1);
        step(MDRO | ZI, 16'h0, 1'b0);
        step(ZO, 16'h0, 1'b0);
        check("R3 passthrough", 32'(bus_o), 32'hABCD);
        step(MDRO | ZI | SCC, 16'h0, 1'b0);
        step(30'd0, 16'h0, 1'b0);
        check("R6 passthrough NZVC", 32'(cc_o), 32'b1000);

        // R5 Z holds when not loaded
        step(ro(1), 16'h0, 1'b0);
        step(ZO, 16'h0, 1'b0);
        check("R5 hold", 32'(bus_o), 32'hABCD);

        // R1 reset mid-run
        @(negedge clk);
        ctrl  = '0;
        rst_n = 1'b0;
        #1;
        check("R1 cc after reset", 32'(cc_o), 32'h0);
        check("R1 mar after reset", 32'(mem_addr), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(ro(2), 16'h0, 1'b0);
        check("R1 gpr after reset", 32'(bus_o), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule